// File: doc/BRIEF.md
# Dataflow Node Firing Controller

This block is the control engine of one processing element in a dataflow fabric. There is no program counter. Incoming operand messages are written into the operand slots of graph nodes held in a node memory. A node fires once both of its operand slots hold a value. Its operation code and operands then go to an arithmetic unit through a valid/ready request. When the single result comes back, the controller walks that node's destination list in a separate edge memory. It emits one output message per destination, and each message carries the result.

Before a run, the node entries and the edge memory are loaded through a configuration write port. A node entry holds an operation code, an edge-list base pointer and a fan-out count. A start pulse then opens the run with a target number of firings. Complete nodes wait in a ready queue and are issued in the order they became complete. Only one operation is outstanding at a time, from issue until its last output message has been accepted. When the target number of firings is reached, the run ends. Input acceptance stops at that point, and a busy-cycle counter freezes at the number of cycles the run lasted.

Top module: `df_fire_ctrl`

## Requirements
- R1: After reset, `out_valid`, `fpu_req_valid`, `in_ready`, `done` and `dup_err` are 0 and `busy_cycles` is 0.
- R2: An operand address is DEST_W bits wide. Bit 0 selects the slot (0 = operand A, 1 = operand B) and bits [DEST_W-1:1] select the node index. Operands may arrive in either order and still land in the right slot.
- R3: A node is issued only when both of its slots are valid. A node holding a single operand never raises `fpu_req_valid`.
- R4: An issued request carries the node's programmed 2-bit operation code unchanged on `fpu_op`, with slot A on `fpu_a` and slot B on `fpu_b`. The arithmetic unit in the bench interprets the code as 0 = A-B, 1 = A*B, 2 = A/B and 3 = A.
- R5: At most one operation is outstanding. No new request is raised between an issue and the acceptance of that node's last output message.
- R6: Complete nodes are issued in the order in which they became complete.
- R7: A result is sent as one message per edge entry, in edge-memory order from the node's base pointer, and each message carries the result. While `out_ready` is low, `out_valid`, `out_dest` and `out_data` hold.
- R8: A node with a fan-out count of 0 fires and produces no output message.
- R9: Firing clears both valid bits of the node. The same node accepts fresh operands afterwards without an error and fires again.
- R10: An operand for a slot that is already valid is dropped and leaves the stored value unchanged. `dup_err` is high for one cycle, the cycle after the operand is accepted.
- R11: When the number of completed firings reaches `fire_target` (which must be at least 1), `done` rises and `in_ready` falls. No request is raised until the next `start`.
- R12: `busy_cycles` is cleared by `start`. It counts one per clock edge while the run is active, including the edge that completes the run, and then holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run; latches `fire_target` and clears the counters |
| fire_target | input | CNT_W | Number of firings that end the run |
| cfg_node_we | input | 1 | Writes one node entry and clears its valid bits |
| cfg_node_idx | input | IDX_W | Node index to configure |
| cfg_opcode | input | 2 | Operation code of the node |
| cfg_base | input | EDGE_AW | First edge-memory entry of the node |
| cfg_fanout | input | FAN_W | Number of destinations of the node |
| cfg_edge_we | input | 1 | Writes one edge-memory entry |
| cfg_edge_addr | input | EDGE_AW | Edge-memory address |
| cfg_edge_dest | input | DEST_W | Destination address stored in the entry |
| in_valid | input | 1 | Incoming operand message is valid |
| in_ready | output | 1 | Operands are accepted (run active) |
| in_dest | input | DEST_W | Target node index and slot of the operand |
| in_data | input | DATA_W | Operand value |
| fpu_req_valid | output | 1 | Operation request to the arithmetic unit |
| fpu_req_ready | input | 1 | Arithmetic unit accepts the request |
| fpu_op | output | 2 | Operation code of the issued node |
| fpu_a | output | DATA_W | Operand A |
| fpu_b | output | DATA_W | Operand B |
| fpu_rsp_valid | input | 1 | Result is valid for one cycle |
| fpu_rsp_data | input | DATA_W | Result value |
| out_valid | output | 1 | Outgoing message is valid |
| out_ready | input | 1 | Output buffer accepts the message |
| out_dest | output | DEST_W | Destination address of the message |
| out_data | output | DATA_W | Result carried by the message |
| dup_err | output | 1 | An operand hit an already valid slot and was dropped |
| done | output | 1 | The run reached its firing target |
| busy_cycles | output | CYC_W | Cycles spent in the last or current run |

## Verification
The in-RTL properties assume the following: the graph memories are not rewritten while a run is active, `start` is pulsed only when no run is active, and the arithmetic unit returns exactly one response per accepted request. From these it follows that a node sits in the ready queue at most once, so the queue can never overflow. The bench respects all of this. It loads every node and edge entry before pulsing `start`, uses firing targets of at least 1, and keeps each fan-out list inside the edge memory. Its fixed-latency arithmetic stand-in raises `fpu_req_ready` only while nothing is pending and answers each request exactly once.

// File: rtl/df_pkg.sv
package df_pkg;
   // Operation codes; the arithmetic unit gives them meaning.
   typedef enum logic [1:0] {
      OPC_SUB  = 2'd0,
      OPC_MUL  = 2'd1,
      OPC_DIV  = 2'd2,
      OPC_PASS = 2'd3
   } df_opc_e;

   // Issue/fan-out sequencer phases.
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_WAIT = 2'd1,
      PH_SEND = 2'd2
   } df_phase_e;
endpackage

// File: rtl/df_node_store.sv
module df_node_store #(
   parameter  int NODES   = 16,
   parameter  int DATA_W  = 64,
   parameter  int EDGE_AW = 5,
   parameter  int FAN_W   = 3,
   localparam int IDX_W   = $clog2(NODES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [IDX_W-1:0]   cfg_idx,
   input  logic [1:0]         cfg_op,
   input  logic [EDGE_AW-1:0] cfg_base,
   input  logic [FAN_W-1:0]   cfg_fan,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic               wr_slot,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               clr_en,
   input  logic [IDX_W-1:0]   clr_idx,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [1:0]         rd_op,
   output logic [DATA_W-1:0]  rd_a,
   output logic [DATA_W-1:0]  rd_b,
   output logic [EDGE_AW-1:0] rd_base,
   output logic [FAN_W-1:0]   rd_fan,
   output logic               ready_push,
   output logic               dup_flag
);
   logic [1:0]         op_q   [NODES];
   logic [DATA_W-1:0]  a_q    [NODES];
   logic [DATA_W-1:0]  b_q    [NODES];
   logic [EDGE_AW-1:0] base_q [NODES];
   logic [FAN_W-1:0]   fan_q  [NODES];
   logic [NODES-1:0]   va_q, vb_q;

   logic clr_hit, va_eff, vb_eff, mine, other, dup_now;

   // A slot being cleared by a firing in this same cycle counts as empty.
   always_comb begin
      clr_hit    = clr_en && (clr_idx == wr_idx);
      va_eff     = va_q[wr_idx] && !clr_hit;
      vb_eff     = vb_q[wr_idx] && !clr_hit;
      mine       = wr_slot ? vb_eff : va_eff;
      other      = wr_slot ? va_eff : vb_eff;
      dup_now    = wr_en && mine;
      ready_push = wr_en && !mine && other;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         va_q     <= '0;
         vb_q     <= '0;
         dup_flag <= 1'b0;
      end else begin
         dup_flag <= dup_now;
         for (int n = 0; n < NODES; n++) begin
            if (cfg_we && cfg_idx == IDX_W'(n)) begin
               op_q[n]   <= cfg_op;
               base_q[n] <= cfg_base;
               fan_q[n]  <= cfg_fan;
               va_q[n]   <= 1'b0;
               vb_q[n]   <= 1'b0;
            end else begin
               if (clr_en && clr_idx == IDX_W'(n)) begin
                  va_q[n] <= 1'b0;
                  vb_q[n] <= 1'b0;
               end
               if (wr_en && wr_idx == IDX_W'(n) && !dup_now) begin
                  if (wr_slot) begin
                     b_q[n]  <= wr_data;
                     vb_q[n] <= 1'b1;
                  end else begin
                     a_q[n]  <= wr_data;
                     va_q[n] <= 1'b1;
                  end
               end
            end
         end
      end
   end

   assign rd_op   = op_q[rd_idx];
   assign rd_a    = a_q[rd_idx];
   assign rd_b    = b_q[rd_idx];
   assign rd_base = base_q[rd_idx];
   assign rd_fan  = fan_q[rd_idx];

   // R10: the error pulse only follows an accepted operand
   assert_dup_follows_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dup_flag |-> $past(wr_en));

   // R3: a queued node has both slots filled on the following cycle
   assert_push_both_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_push && !cfg_we) |=> (va_q[$past(wr_idx)] && vb_q[$past(wr_idx)]));
endmodule

// File: rtl/df_ready_fifo.sv
module df_ready_fifo #(
   parameter  int DEPTH = 16,
   parameter  int W     = 4,
   localparam int PW    = $clog2(DEPTH)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   generate
      if (DEPTH < 2 || (2 ** PW) != DEPTH) begin : g_bad_depth
         $error("df_ready_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [PW:0]   cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) begin
            mem[wp] <= push_data;
            wp      <= wp + PW'(1);
         end
         if (pop) rp <= rp + PW'(1);
         case ({push, pop})
            2'b10:   cnt <= cnt + (PW+1)'(1);
            2'b01:   cnt <= cnt - (PW+1)'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   assign head  = mem[rp];
   assign empty = (cnt == '0);
   assign full  = (cnt == (PW+1)'(DEPTH));

   // R6: queue never overruns or underruns
   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!full || pop));
   assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/df_edge_mem.sv
module df_edge_mem #(
   parameter  int EDGES  = 32,
   parameter  int DEST_W = 5,
   localparam int AW     = $clog2(EDGES)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DEST_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DEST_W-1:0] rdata
);
   generate
      if ((2 ** AW) != EDGES) begin : g_bad_edges
         $error("df_edge_mem: EDGES must be a power of two");
      end
   endgenerate

   logic [DEST_W-1:0] mem [EDGES];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/df_fire_ctrl.sv
module df_fire_ctrl #(
   parameter  int NODES   = 16,
   parameter  int EDGES   = 32,
   parameter  int DATA_W  = 64,
   parameter  int FAN_W   = 3,
   parameter  int CNT_W   = 16,
   parameter  int CYC_W   = 32,
   localparam int IDX_W   = $clog2(NODES),
   localparam int EDGE_AW = $clog2(EDGES),
   localparam int DEST_W  = IDX_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [CNT_W-1:0]   fire_target,
   input  logic               cfg_node_we,
   input  logic [IDX_W-1:0]   cfg_node_idx,
   input  logic [1:0]         cfg_opcode,
   input  logic [EDGE_AW-1:0] cfg_base,
   input  logic [FAN_W-1:0]   cfg_fanout,
   input  logic               cfg_edge_we,
   input  logic [EDGE_AW-1:0] cfg_edge_addr,
   input  logic [DEST_W-1:0]  cfg_edge_dest,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [DEST_W-1:0]  in_dest,
   input  logic [DATA_W-1:0]  in_data,
   output logic               fpu_req_valid,
   input  logic               fpu_req_ready,
   output logic [1:0]         fpu_op,
   output logic [DATA_W-1:0]  fpu_a,
   output logic [DATA_W-1:0]  fpu_b,
   input  logic               fpu_rsp_valid,
   input  logic [DATA_W-1:0]  fpu_rsp_data,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [DEST_W-1:0]  out_dest,
   output logic [DATA_W-1:0]  out_data,
   output logic               dup_err,
   output logic               done,
   output logic [CYC_W-1:0]   busy_cycles
);
   import df_pkg::*;

   generate
      if (NODES < 2 || FAN_W < 1 || CNT_W < 1) begin : g_bad_params
         $error("df_fire_ctrl: NODES >= 2, FAN_W >= 1 and CNT_W >= 1 are required");
      end
   endgenerate

   df_phase_e          phase;
   logic               running, done_q;
   logic [IDX_W-1:0]   cur_idx, rq_head, rd_idx;
   logic [DATA_W-1:0]  res_q;
   logic [EDGE_AW-1:0] ptr, rd_base;
   logic [FAN_W-1:0]   remain, rd_fan;
   logic [CNT_W-1:0]   fired, target_q;
   logic [CYC_W-1:0]   busy_q;
   logic               wr_en, ready_push, rq_empty, rq_full;
   logic               issue, rsp_take, send_take, node_end;

   assign in_ready      = running;
   assign wr_en         = in_valid && running;
   assign fpu_req_valid = running && (phase == PH_IDLE) && !rq_empty;
   assign issue         = fpu_req_valid && fpu_req_ready;
   assign rsp_take      = (phase == PH_WAIT) && fpu_rsp_valid;
   assign send_take     = (phase == PH_SEND) && out_ready;
   assign node_end      = (rsp_take && rd_fan == '0) ||
                          (send_take && remain == FAN_W'(1));
   assign rd_idx        = (phase == PH_IDLE) ? rq_head : cur_idx;

   df_node_store #(.NODES(NODES), .DATA_W(DATA_W), .EDGE_AW(EDGE_AW), .FAN_W(FAN_W)) u_nodes (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_node_we), .cfg_idx(cfg_node_idx), .cfg_op(cfg_opcode),
      .cfg_base(cfg_base), .cfg_fan(cfg_fanout),
      .wr_en(wr_en), .wr_idx(in_dest[DEST_W-1:1]), .wr_slot(in_dest[0]), .wr_data(in_data),
      .clr_en(issue), .clr_idx(rq_head),
      .rd_idx(rd_idx), .rd_op(fpu_op), .rd_a(fpu_a), .rd_b(fpu_b),
      .rd_base(rd_base), .rd_fan(rd_fan),
      .ready_push(ready_push), .dup_flag(dup_err)
   );

   df_ready_fifo #(.DEPTH(NODES), .W(IDX_W)) u_rq (
      .clk(clk), .rst_n(rst_n),
      .push(ready_push), .push_data(in_dest[DEST_W-1:1]),
      .pop(issue), .head(rq_head), .empty(rq_empty), .full(rq_full)
   );

   df_edge_mem #(.EDGES(EDGES), .DEST_W(DEST_W)) u_edges (
      .clk(clk), .we(cfg_edge_we), .waddr(cfg_edge_addr), .wdata(cfg_edge_dest),
      .raddr(ptr), .rdata(out_dest)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         running  <= 1'b0;
         done_q   <= 1'b0;
         cur_idx  <= '0;
         res_q    <= '0;
         ptr      <= '0;
         remain   <= '0;
         fired    <= '0;
         target_q <= '0;
         busy_q   <= '0;
      end else if (start) begin
         phase    <= PH_IDLE;
         running  <= 1'b1;
         done_q   <= 1'b0;
         fired    <= '0;
         target_q <= fire_target;
         busy_q   <= '0;
      end else begin
         if (running) busy_q <= busy_q + CYC_W'(1);
         unique case (phase)
            PH_IDLE: if (issue) begin
               cur_idx <= rq_head;
               phase   <= PH_WAIT;
            end
            PH_WAIT: if (rsp_take) begin
               res_q  <= fpu_rsp_data;
               ptr    <= rd_base;
               remain <= rd_fan;
               phase  <= (rd_fan == '0) ? PH_IDLE : PH_SEND;
            end
            PH_SEND: if (send_take) begin
               ptr    <= ptr + EDGE_AW'(1);
               remain <= remain - FAN_W'(1);
               if (remain == FAN_W'(1)) phase <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
         if (node_end) begin
            fired <= fired + CNT_W'(1);
            if (fired + CNT_W'(1) == target_q) begin
               running <= 1'b0;
               done_q  <= 1'b1;
            end
         end
      end
   end

   assign out_valid   = (phase == PH_SEND);
   assign out_data    = res_q;
   assign done        = done_q;
   assign busy_cycles = busy_q;

   // R5: an accepted request is never followed directly by another one
   assert_one_in_flight_R5: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> !fpu_req_valid);

   // R6: the ready queue always has room for a newly completed node
   assert_queue_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ready_push |-> (!rq_full || issue));

   // R7: a stalled message holds its destination and data
   assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !start) |=>
         (out_valid && $stable(out_dest) && $stable(out_data)));

   // R11: a finished run is quiet
   assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!fpu_req_valid && !in_ready));

   // R12: the busy counter freezes outside a run
   assert_busy_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !start) |=> $stable(busy_cycles));
endmodule

// File: tb/df_fire_ctrl_bench.sv
module df_fire_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 3;
   localparam int NODES = 16, EDGES = 32, DATA_W = 64, FAN_W = 3, CNT_W = 16, CYC_W = 32;
   localparam int IDX_W = 4, EDGE_AW = 5, DEST_W = 5;

   // vector table: operand A, operand B, opcode, B sent first
   localparam int NV = 6;
   localparam int VA  [NV] = '{7, -6, 1, 9, 5, 13};
   localparam int VB  [NV] = '{3,  4, 3, 2, 11, 0};
   localparam int VOP [NV] = '{0,  1, 2, 2, 0,  3};
   localparam int VORD[NV] = '{0,  1, 0, 1, 1,  0};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [CNT_W-1:0] fire_target = '0;
   logic cfg_node_we = 1'b0;
   logic [IDX_W-1:0] cfg_node_idx = '0;
   logic [1:0] cfg_opcode = '0;
   logic [EDGE_AW-1:0] cfg_base = '0;
   logic [FAN_W-1:0] cfg_fanout = '0;
   logic cfg_edge_we = 1'b0;
   logic [EDGE_AW-1:0] cfg_edge_addr = '0;
   logic [DEST_W-1:0] cfg_edge_dest = '0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [DEST_W-1:0] in_dest = '0;
   logic [DATA_W-1:0] in_data = '0;
   logic fpu_req_valid, fpu_req_ready;
   logic [1:0] fpu_op;
   logic [DATA_W-1:0] fpu_a, fpu_b;
   logic fpu_rsp_valid;
   logic [DATA_W-1:0] fpu_rsp_data;
   logic out_valid;
   logic out_ready = 1'b1;
   logic [DEST_W-1:0] out_dest;
   logic [DATA_W-1:0] out_data;
   logic dup_err, done;
   logic [CYC_W-1:0] busy_cycles;

   int checks = 0;
   int fails = 0;
   int cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   df_fire_ctrl #(.NODES(NODES), .EDGES(EDGES), .DATA_W(DATA_W), .FAN_W(FAN_W),
                  .CNT_W(CNT_W), .CYC_W(CYC_W)) u_df_fire_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .fire_target(fire_target),
      .cfg_node_we(cfg_node_we), .cfg_node_idx(cfg_node_idx), .cfg_opcode(cfg_opcode),
      .cfg_base(cfg_base), .cfg_fanout(cfg_fanout),
      .cfg_edge_we(cfg_edge_we), .cfg_edge_addr(cfg_edge_addr), .cfg_edge_dest(cfg_edge_dest),
      .in_valid(in_valid), .in_ready(in_ready), .in_dest(in_dest), .in_data(in_data),
      .fpu_req_valid(fpu_req_valid), .fpu_req_ready(fpu_req_ready), .fpu_op(fpu_op),
      .fpu_a(fpu_a), .fpu_b(fpu_b), .fpu_rsp_valid(fpu_rsp_valid), .fpu_rsp_data(fpu_rsp_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_dest(out_dest), .out_data(out_data),
      .dup_err(dup_err), .done(done), .busy_cycles(busy_cycles)
   );

   // ---------------- fixed-latency arithmetic stand-in ----------------
   function automatic logic [63:0] fpu_model(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
      real ra, rb, r;
      ra = $bitstoreal(a);
      rb = $bitstoreal(b);
      case (op)
         2'd0:    r = ra - rb;
         2'd1:    r = ra * rb;
         2'd2:    r = ra / rb;
         default: r = ra;
      endcase
      return $realtobits(r);
   endfunction

   logic stub_busy = 1'b0;
   int stub_cnt = 0;
   logic [63:0] stub_res = '0;
   logic [1:0] last_op = '0;
   int req_n = 0;
   int req_cyc [8];

   assign fpu_req_ready = !stub_busy;

   always @(posedge clk) begin
      if (!rst_n) begin
         stub_busy     <= 1'b0;
         fpu_rsp_valid <= 1'b0;
         fpu_rsp_data  <= '0;
      end else begin
         fpu_rsp_valid <= 1'b0;
         if (fpu_req_valid && fpu_req_ready) begin
            stub_res  <= fpu_model(fpu_op, fpu_a, fpu_b);
            stub_cnt  <= LAT;
            stub_busy <= 1'b1;
            last_op   <= fpu_op;
            if (req_n < 8) req_cyc[req_n] <= cyc;
            req_n <= req_n + 1;
         end else if (stub_busy) begin
            if (stub_cnt == 1) begin
               fpu_rsp_valid <= 1'b1;
               fpu_rsp_data  <= stub_res;
               stub_busy     <= 1'b0;
            end
            stub_cnt <= stub_cnt - 1;
         end
      end
   end

   // ---------------- output monitor ----------------
   int got_n = 0;
   logic [DEST_W-1:0] got_dest [16];
   logic [63:0] got_data [16];
   int out_cyc [16];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n && out_valid && out_ready) begin
         if (got_n < 16) begin
            got_dest[got_n] <= out_dest;
            got_data[got_n] <= out_data;
            out_cyc[got_n]  <= cyc;
         end
         got_n <= got_n + 1;
      end
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      if (cyc > 50000) begin
         fails = fails + 1;
         $display("FAIL watchdog (all requirements) actual=%0d cycles expected=<50000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   // ---------------- helpers ----------------
   function automatic logic [63:0] expect_val(input int op, input int a, input int b);
      real ra, rb;
      ra = real'(a);
      rb = real'(b);
      if (op == 0) return $realtobits(ra - rb);
      if (op == 1) return $realtobits(ra * rb);
      if (op == 2) return $realtobits(ra / rb);
      return $realtobits(ra);
   endfunction

   function automatic logic [DEST_W-1:0] dst(input int node, input bit slot);
      return {IDX_W'(node), slot};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg_node(input int idx, input int op, input int base, input int fan);
      cfg_node_idx = IDX_W'(idx);
      cfg_opcode   = 2'(op);
      cfg_base     = EDGE_AW'(base);
      cfg_fanout   = FAN_W'(fan);
      cfg_node_we  = 1'b1;
      @(negedge clk);
      cfg_node_we  = 1'b0;
   endtask

   task automatic cfg_edge(input int addr, input logic [DEST_W-1:0] d);
      cfg_edge_addr = EDGE_AW'(addr);
      cfg_edge_dest = d;
      cfg_edge_we   = 1'b1;
      @(negedge clk);
      cfg_edge_we   = 1'b0;
   endtask

   task automatic send(input logic [DEST_W-1:0] d, input int v);
      in_dest  = d;
      in_data  = $realtobits(real'(v));
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic start_run(input int t);
      got_n       = 0;
      req_n       = 0;
      fire_target = CNT_W'(t);
      start       = 1'b1;
      @(negedge clk);
      start       = 1'b0;
   endtask

   task automatic wait_done(input string tag);
      for (int i = 0; i < 400; i++) begin
         if (done) break;
         @(negedge clk);
      end
      chk(done == 1'b1, tag, 64'(done), 64'd1);
   endtask

   // ---------------- stimulus ----------------
   initial begin
      logic [CYC_W-1:0] busy_snap;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(out_valid == 1'b0 && fpu_req_valid == 1'b0 && in_ready == 1'b0, "R1 idle outputs in reset",
          64'({out_valid, fpu_req_valid, in_ready}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 1'b0 && dup_err == 1'b0 && busy_cycles == '0, "R1 status after reset",
          64'({done, dup_err, busy_cycles}), 64'd0);

      // table walk: R2 slot/node decoding, R4 opcode forwarding
      for (int vi = 0; vi < NV; vi++) begin
         cfg_node(vi, VOP[vi], vi, 1);
         cfg_edge(vi, dst(15 - vi, 1'b1));
         start_run(1);
         if (VORD[vi] != 0) begin
            send(dst(vi, 1'b1), VB[vi]);
            send(dst(vi, 1'b0), VA[vi]);
         end else begin
            send(dst(vi, 1'b0), VA[vi]);
            send(dst(vi, 1'b1), VB[vi]);
         end
         wait_done("R11 table run completes");
         chk(got_n == 1, "R7 table single message", 64'(got_n), 64'd1);
         chk(got_data[0] == expect_val(VOP[vi], VA[vi], VB[vi]), "R2 table result value",
             got_data[0], expect_val(VOP[vi], VA[vi], VB[vi]));
         chk(got_dest[0] == dst(15 - vi, 1'b1), "R7 table destination",
             64'(got_dest[0]), 64'(dst(15 - vi, 1'b1)));
         chk(last_op == 2'(VOP[vi]), "R4 opcode forwarded", 64'(last_op), 64'(VOP[vi]));
      end

      // R3: a single operand never fires
      cfg_node(9, 0, 9, 1);
      cfg_edge(9, 5'd26);
      start_run(1);
      send(dst(9, 1'b0), 20);
      repeat (12) @(negedge clk);
      chk(fpu_req_valid == 1'b0 && req_n == 0, "R3 half-filled node not issued", 64'(req_n), 64'd0);
      send(dst(9, 1'b1), 8);
      wait_done("R3 node fires after second operand");
      chk(got_n == 1 && got_data[0] == expect_val(0, 20, 8), "R3 result after firing",
          got_data[0], expect_val(0, 20, 8));

      // R8 and R12: zero fan-out and exact busy count
      cfg_node(10, 1, 0, 0);
      start_run(1);
      send(dst(10, 1'b0), 2);
      send(dst(10, 1'b1), 3);
      wait_done("R8 zero fan-out run completes");
      chk(got_n == 0, "R8 zero fan-out emits nothing", 64'(got_n), 64'd0);
      chk(req_n == 1, "R8 zero fan-out node still fired", 64'(req_n), 64'd1);
      chk(busy_cycles == CYC_W'(4 + LAT), "R12 busy cycle count", 64'(busy_cycles), 64'(4 + LAT));
      busy_snap = busy_cycles;
      repeat (5) @(negedge clk);
      chk(busy_cycles == busy_snap, "R12 counter holds after done", 64'(busy_cycles), 64'(busy_snap));
      chk(in_ready == 1'b0 && fpu_req_valid == 1'b0, "R11 quiet after done",
          64'({in_ready, fpu_req_valid}), 64'd0);

      // R7: three destinations under back-pressure
      cfg_node(11, 1, 20, 3);
      cfg_edge(20, 5'd6);
      cfg_edge(21, 5'd25);
      cfg_edge(22, 5'd13);
      out_ready = 1'b0;
      start_run(1);
      chk(done == 1'b0 && busy_cycles == '0, "R12 start clears status", 64'(busy_cycles), 64'd0);
      send(dst(11, 1'b0), 4);
      send(dst(11, 1'b1), 5);
      for (int i = 0; i < 40; i++) begin
         if (out_valid) break;
         @(negedge clk);
      end
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b1 && got_n == 0 && out_dest == 5'd6, "R7 message held while stalled",
          64'(out_dest), 64'd6);
      out_ready = 1'b1;
      wait_done("R7 fan-out run completes");
      chk(got_n == 3, "R7 three messages", 64'(got_n), 64'd3);
      chk(got_dest[0] == 5'd6 && got_dest[1] == 5'd25 && got_dest[2] == 5'd13, "R7 edge order",
          64'({got_dest[0], got_dest[1], got_dest[2]}), 64'({5'd6, 5'd25, 5'd13}));
      chk(got_data[0] == expect_val(1, 4, 5) && got_data[2] == expect_val(1, 4, 5), "R7 data copied",
          got_data[2], expect_val(1, 4, 5));

      // R10: duplicate operand dropped
      cfg_node(12, 0, 23, 1);
      cfg_edge(23, 5'd17);
      start_run(1);
      send(dst(12, 1'b0), 5);
      chk(dup_err == 1'b0, "R10 first operand no error", 64'(dup_err), 64'd0);
      send(dst(12, 1'b0), 9);
      chk(dup_err == 1'b1, "R10 duplicate flagged", 64'(dup_err), 64'd1);
      send(dst(12, 1'b1), 2);
      chk(dup_err == 1'b0, "R10 flag is one cycle", 64'(dup_err), 64'd0);
      wait_done("R10 run completes");
      chk(got_data[0] == expect_val(0, 5, 2), "R10 stored value kept", got_data[0], expect_val(0, 5, 2));

      // R6 and R5: queue order and single operation in flight
      cfg_node(13, 1, 24, 2);
      cfg_node(14, 1, 26, 2);
      cfg_node(15, 1, 28, 2);
      cfg_edge(24, 5'd1);
      cfg_edge(25, 5'd2);
      cfg_edge(26, 5'd3);
      cfg_edge(27, 5'd4);
      cfg_edge(28, 5'd7);
      cfg_edge(29, 5'd8);
      start_run(3);
      send(dst(13, 1'b0), 2);
      send(dst(14, 1'b0), 4);
      send(dst(15, 1'b0), 6);
      send(dst(15, 1'b1), 7);
      send(dst(13, 1'b1), 3);
      send(dst(14, 1'b1), 5);
      wait_done("R11 three-node run completes");
      chk(got_n == 6, "R6 six messages", 64'(got_n), 64'd6);
      chk(got_dest[0] == 5'd7 && got_dest[2] == 5'd1 && got_dest[4] == 5'd3, "R6 completion order",
          64'({got_dest[0], got_dest[2], got_dest[4]}), 64'({5'd7, 5'd1, 5'd3}));
      chk(got_data[1] == expect_val(1, 6, 7) && got_data[3] == expect_val(1, 2, 3) &&
          got_data[5] == expect_val(1, 4, 5), "R6 results follow order", got_data[5], expect_val(1, 4, 5));
      chk(req_n == 3 && req_cyc[1] > out_cyc[1] && req_cyc[2] > out_cyc[3], "R5 one operation in flight",
          64'(req_cyc[1]), 64'(out_cyc[1]));

      // R9: node refires with fresh operands
      start_run(1);
      send(dst(15, 1'b0), 3);
      chk(dup_err == 1'b0, "R9 slot A cleared after firing", 64'(dup_err), 64'd0);
      send(dst(15, 1'b1), 3);
      chk(dup_err == 1'b0, "R9 slot B cleared after firing", 64'(dup_err), 64'd0);
      wait_done("R9 refire completes");
      chk(got_n == 2 && got_data[0] == expect_val(1, 3, 3), "R9 refire result",
          got_data[0], expect_val(1, 3, 3));

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule